// File: doc/BRIEF.md
# Per-source interrupt event state buffer

This block holds a two-bit event state for each of a bank of interrupt sources and updates it from two kinds of traffic: trigger events, which arrive from a trigger-page store or an edge detector, and register accesses at fixed offsets within a source's management page. The offset, together with whether the access is a load or a store, selects the operation. Stores carry no data lanes at all, because the value written never matters. A load gives back the state the source held just before the access and applies its update in the same cycle.

The upper state bit (P) records that an event has been forwarded and has not yet been retired. The lower bit (Q) records a further event that arrived while P was set. With P clear, Q alone is the masked encoding. When a source is allowed to notify, the block sends a one-cycle pulse on the bit of `fwd_vec` that belongs to that source, and the interrupt router downstream of this block consumes it. Software retires an event with an end-of-interrupt (EOI) access. If a queued event is present at that point, the block forwards it again.

Top module: `esb_pq_bank`

## Requirements
- R1: After reset every source holds PQ=01 (masked), `rd_valid` is low and `fwd_vec` is zero.
- R2: A load produces `rd_valid` high for exactly one cycle, in the cycle after the load. For a decoded load, `rd_data[1]` is the old P, `rd_data[0]` is the old Q, and the upper bits are zero.
- R3: A trigger moves PQ 00 to 10 and forwards an event. It moves 10 to 11, leaves 11 at 11, and leaves 01 at 01. Only the move from 00 forwards.
- R4: A load at offset 0x000 is an EOI. It moves 10 to 00, and it moves 11 to 10 and forwards an event. It leaves 00 and 01 unchanged.
- R5: A store at offset 0x400 is an EOI with the same transitions as R4, and it produces no read response.
- R6: A load at offset 0xC00 sets PQ to 00 (unmask).
- R7: A load at offset 0xD00 sets PQ to 01 (mask). While a source is masked, triggers forward nothing.
- R8: A load at any other offset returns all ones and changes no state. A store at any offset other than 0x400 changes no state and produces no response.
- R9: When a register access and a trigger address the same source in the same cycle, the access is applied first and the trigger acts on its result.
- R10: Forward pulses appear in the cycle after the event that caused them, on the bit indexed by the source number. Sources are independent, so an access to one source and a trigger to another in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | A trigger event for `trig_src` this cycle |
| trig_src | input | SRC_W | Source number of the trigger |
| acc_valid | input | 1 | A register access this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_src | input | SRC_W | Source page of the access |
| acc_off | input | OFF_W | Offset within the page |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | RD_W | Old PQ state, or all ones for an undecoded load |
| fwd_vec | output | NSRC | One-cycle forward pulse, one bit per source |

## Verification
The assertions take for granted that `trig_src` and `acc_src` always index an existing source, that at most one access and one trigger arrive per cycle, and that inputs stay idle while reset is applied. The bench only draws source numbers below NSRC and holds every input low during reset. It therefore stays inside these assumptions while it covers every offset class, both access directions and same-source collisions. Its random phase mixes decoded offsets with undecoded ones, so masking, unmasking and re-forwarding occur in many different orders.

// File: rtl/esb_pkg.sv
// Shared definitions for the event state buffer: operation codes and the
// page offsets the decoder recognises. Offsets are fixed by the software view.
package esb_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_EOI,
        OP_UNMASK,
        OP_MASK,
        OP_BAD_LOAD
    } esb_op_e;

    localparam logic [11:0] OFF_LD_EOI = 12'h000;
    localparam logic [11:0] OFF_ST_EOI = 12'h400;
    localparam logic [11:0] OFF_UNMASK = 12'hC00;
    localparam logic [11:0] OFF_MASK   = 12'hD00;

    localparam logic [1:0] PQ_IDLE   = 2'b00;
    localparam logic [1:0] PQ_MASKED = 2'b01;
    localparam logic [1:0] PQ_PEND   = 2'b10;
    localparam logic [1:0] PQ_QUEUED = 2'b11;
endpackage

// File: rtl/esb_op_decode.sv
// Access decoder: turns (direction, offset) into one operation and says
// whether a read response is owed. Assumes OFF_W >= 12; any offset bits
// above bit 11 must be zero for a match.
module esb_op_decode
    import esb_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFF_W-1:0] acc_off,
    output esb_op_e          op,
    output logic             rsp
);
    // Classify the access; stores never respond, loads always do.
    always_comb begin
        op  = OP_NONE;
        rsp = 1'b0;
        if (acc_valid) begin
            if (acc_write) begin
                if (acc_off == OFF_W'(OFF_ST_EOI)) op = OP_EOI;
            end else begin
                rsp = 1'b1;
                if (acc_off == OFF_W'(OFF_LD_EOI))      op = OP_EOI;
                else if (acc_off == OFF_W'(OFF_UNMASK)) op = OP_UNMASK;
                else if (acc_off == OFF_W'(OFF_MASK))   op = OP_MASK;
                else                                    op = OP_BAD_LOAD;
            end
        end
    end
endmodule

// File: rtl/esb_pq_cell.sv
// One source's PQ state machine. The register access is applied first and
// the trigger then acts on its result, so a collision within a cycle is
// well defined. At most one forward can result per cycle.
module esb_pq_cell
    import esb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_hit,
    input  esb_op_e    op,
    input  logic       trig_hit,
    output logic [1:0] pq,
    output logic       fwd
);
    logic [1:0] mid_pq, nxt_pq;
    logic       fwd_acc, fwd_trig;

    // Stage 1: effect of the register access on the current state.
    always_comb begin
        mid_pq  = pq;
        fwd_acc = 1'b0;
        if (acc_hit) begin
            unique case (op)
                OP_EOI: begin
                    if (pq == PQ_PEND) mid_pq = PQ_IDLE;
                    else if (pq == PQ_QUEUED) begin
                        mid_pq  = PQ_PEND;
                        fwd_acc = 1'b1;
                    end
                end
                OP_UNMASK: mid_pq = PQ_IDLE;
                OP_MASK:   mid_pq = PQ_MASKED;
                default:   mid_pq = pq;
            endcase
        end
    end

    // Stage 2: effect of a trigger on the post-access state.
    always_comb begin
        nxt_pq   = mid_pq;
        fwd_trig = 1'b0;
        if (trig_hit) begin
            unique case (mid_pq)
                PQ_IDLE: begin
                    nxt_pq   = PQ_PEND;
                    fwd_trig = 1'b1;
                end
                PQ_PEND:   nxt_pq = PQ_QUEUED;
                default:   nxt_pq = mid_pq;
            endcase
        end
    end

    // State and forward-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq  <= PQ_MASKED;
            fwd <= 1'b0;
        end else begin
            pq  <= nxt_pq;
            fwd <= fwd_acc | fwd_trig;
        end
    end
endmodule

// File: rtl/esb_pq_bank.sv
// Bank of NSRC event state cells with one shared access port and one
// trigger port. A load returns the pre-access state one cycle later.
// Assumes trig_src and acc_src are below NSRC.
module esb_pq_bank
    import esb_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int OFF_W = 12,
    parameter int RD_W  = 8,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid,
    input  logic [SRC_W-1:0] trig_src,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [SRC_W-1:0] acc_src,
    input  logic [OFF_W-1:0] acc_off,
    output logic             rd_valid,
    output logic [RD_W-1:0]  rd_data,
    output logic [NSRC-1:0]  fwd_vec
);
    esb_op_e    op;
    logic       rsp;
    logic [1:0] pq_all [NSRC];

    esb_op_decode #(.OFF_W(OFF_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_off   (acc_off),
        .op        (op),
        .rsp       (rsp)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        esb_pq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_hit  (acc_valid && (acc_src == SRC_W'(i))),
            .op       (op),
            .trig_hit (trig_valid && (trig_src == SRC_W'(i))),
            .pq       (pq_all[i]),
            .fwd      (fwd_vec[i])
        );
    end

    // Load response: old state of the addressed source, or all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rsp;
            rd_data  <= (op == OP_BAD_LOAD) ? '1 : RD_W'(pq_all[acc_src]);
        end
    end
endmodule

// File: rtl/esb_pq_checker.sv
// Port-level properties of the event state buffer, bound into every
// instance of the top. Assumes source numbers are in range.
module esb_pq_checker
    import esb_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int OFF_W = 12,
    parameter int RD_W  = 8,
    parameter int SRC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_valid,
    input logic [SRC_W-1:0] trig_src,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [SRC_W-1:0] acc_src,
    input logic [OFF_W-1:0] acc_off,
    input logic             rd_valid,
    input logic [RD_W-1:0]  rd_data,
    input logic [NSRC-1:0]  fwd_vec
);
    logic is_load, known_off;
    assign is_load   = acc_valid && !acc_write;
    assign known_off = (acc_off == OFF_W'(OFF_LD_EOI)) || (acc_off == OFF_W'(OFF_UNMASK))
                    || (acc_off == OFF_W'(OFF_MASK));

    assert_rsp_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_load));

    assert_known_load_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && known_off) |=> (rd_valid && rd_data[RD_W-1:2] == '0));

    assert_store_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !rd_valid);

    assert_bad_load_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && !known_off) |=> (rd_valid && rd_data == '1));

    assert_idle_no_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_valid && !acc_valid) |=> (fwd_vec == '0));

    assert_fwd_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fwd_vec) <= 2);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assert_fwd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_vec[i] |-> $past((trig_valid && trig_src == SRC_W'(i))
                              || (acc_valid && acc_src == SRC_W'(i))));

        assert_masked_trig_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_valid && trig_src == SRC_W'(i) && !acc_valid
             && $past(is_load && acc_off == OFF_W'(OFF_MASK) && acc_src == SRC_W'(i)))
            |=> !fwd_vec[i]);
    end
endmodule

bind esb_pq_bank esb_pq_checker #(
    .NSRC(NSRC), .OFF_W(OFF_W), .RD_W(RD_W), .SRC_W(SRC_W)
) u_esb_pq_checker (.*);

// File: tb/esb_pq_bank_bench.sv
// Bench: a behavioural reference model of every source's PQ state is
// updated per cycle and all outputs are compared every clock.
module esb_pq_bank_bench;
    localparam int NSRC  = 16;
    localparam int OFF_W = 12;
    localparam int RD_W  = 8;
    localparam int SRC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_valid = 1'b0;
    logic [SRC_W-1:0] trig_src = '0;
    logic             acc_valid = 1'b0;
    logic             acc_write = 1'b0;
    logic [SRC_W-1:0] acc_src = '0;
    logic [OFF_W-1:0] acc_off = '0;
    logic             rd_valid;
    logic [RD_W-1:0]  rd_data;
    logic [NSRC-1:0]  fwd_vec;

    int model [NSRC];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    esb_pq_bank #(.NSRC(NSRC), .OFF_W(OFF_W), .RD_W(RD_W)) u_esb_pq_bank (.*);

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, advance the model, compare after the edge.
    task automatic step(bit tv, int ts, bit av, bit aw, int as, int ao, string tag);
        logic            e_rdv = 1'b0;
        logic [RD_W-1:0] e_rd  = '0;
        logic [NSRC-1:0] e_fwd = '0;
        trig_valid = tv; trig_src = SRC_W'(ts);
        acc_valid = av; acc_write = aw; acc_src = SRC_W'(as); acc_off = OFF_W'(ao);
        if (av) begin
            bit eoi = 1'b0;
            if (!aw) begin
                e_rdv = 1'b1;
                e_rd  = RD_W'(model[as]);
                case (ao)
                    'h000: eoi = 1'b1;
                    'hC00: model[as] = 0;
                    'hD00: model[as] = 1;
                    default: e_rd = '1;
                endcase
            end else if (ao == 'h400) eoi = 1'b1;
            if (eoi) begin
                if (model[as] == 2) model[as] = 0;
                else if (model[as] == 3) begin model[as] = 2; e_fwd[as] = 1'b1; end
            end
        end
        if (tv) begin
            if (model[ts] == 0) begin model[ts] = 2; e_fwd[ts] = 1'b1; end
            else if (model[ts] == 2) model[ts] = 3;
        end
        @(negedge clk);
        chk(tag, "rd_valid", rd_valid, e_rdv);
        if (e_rdv) chk(tag, "rd_data", rd_data, e_rd);
        chk(tag, "fwd_vec", fwd_vec, e_fwd);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        int offs [6] = '{'h000, 'h400, 'hC00, 'hD00, 'h123, 'h800};
        for (int i = 0; i < NSRC; i++) model[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        // R1: every source reads back masked; mask load keeps it masked (R7)
        for (int s = 0; s < NSRC; s++) step(0, 0, 1, 0, s, 'hD00, "R1");
        // R7: masked source ignores triggers
        step(1, 2, 0, 0, 0, 0, "R7");
        // R6: unmask, then R3 trigger walk 00->10->11->11
        step(0, 0, 1, 0, 2, 'hC00, "R6");
        step(1, 2, 0, 0, 0, 0, "R3");
        step(1, 2, 0, 0, 0, 0, "R3");
        step(1, 2, 0, 0, 0, 0, "R3");
        // R4: load EOI 11->10 forwards, 10->00, 00 stays
        step(0, 0, 1, 0, 2, 'h000, "R4");
        step(0, 0, 1, 0, 2, 'h000, "R4");
        step(0, 0, 1, 0, 2, 'h000, "R4");
        // R5: store EOI behaves alike, silent on the read port
        step(0, 0, 1, 0, 3, 'hC00, "R5");
        step(1, 3, 0, 0, 0, 0, "R5");
        step(1, 3, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 3, 'h400, "R5");
        step(0, 0, 1, 1, 3, 'h400, "R5");
        step(0, 0, 1, 0, 3, 'hD00, "R5");
        // R8: undecoded loads and stores leave state alone
        step(0, 0, 1, 0, 3, 'h123, "R8");
        step(0, 0, 1, 1, 3, 'hC00, "R8");
        step(0, 0, 1, 0, 3, 'h400, "R8");
        step(0, 0, 1, 1, 3, 'h000, "R8");
        step(0, 0, 1, 0, 3, 'hC00, "R8");
        // R9: same-source collisions
        step(0, 0, 1, 0, 4, 'hC00, "R9");
        step(1, 4, 0, 0, 0, 0, "R9");
        step(1, 4, 1, 0, 4, 'h000, "R9");
        step(1, 4, 1, 0, 4, 'hD00, "R9");
        step(1, 4, 1, 0, 4, 'hC00, "R9");
        // R10: different sources act together
        step(0, 0, 1, 0, 5, 'hC00, "R10");
        step(1, 5, 1, 0, 6, 'hC00, "R10");
        step(1, 5, 0, 0, 0, 0, "R10");
        step(1, 6, 1, 0, 5, 'h000, "R10");
        // Random mix
        for (int n = 0; n < 3000; n++)
            step(($urandom % 2) == 1, int'($urandom % NSRC), ($urandom % 3) != 0,
                 ($urandom % 3) == 0, int'($urandom % NSRC), offs[$urandom % 6], "R10");
        idle("R10");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule